// File: doc/BRIEF.md
# DMA Channel Address Generator

This block is the address and count datapath of a single legacy-compatible DMA channel. Software programs a page, an address and a transfer count through a small register write port. Each write fills a base copy and a working copy of that register in the same clock. The channel then serves transfer strobes. Each strobe moves the working address one step up or down and lowers the working count by one. Each strobe moves exactly one unit: a byte in byte mode, a word in word mode.

The 24-bit bus address is formed from the working page and address. In byte mode the page sits directly above the 16-bit address. In word mode the whole value moves up by one bit: the lowest output bit is zero and the lowest page bit is dropped. Address wrap stays inside the 16-bit field and never disturbs the page.

When the count runs out, the block raises terminal count for exactly one cycle, in the same cycle as the final strobe. What happens next depends on the reload mode:

- With reload enabled, the next clock restores page, address and count from the base copies, and the channel stays unmasked.
- With reload disabled, the channel masks itself and ignores further strobes until software clears the mask.

Top module: `dma_chan_addr`

## Requirements
- R1: While reset is asserted, busAddr and curCount are zero, masked is 1 and tc is 0.
- R2: A write with wrSel 0 (page), 1 (address) or 2 (count) loads both the base and the working copy of that register. The working value is visible on the outputs after the next clock edge. wrSel 3 changes nothing.
- R3: With modeDown 0, each accepted strobe adds 1 to the working address, modulo 2^16, and subtracts 1 from the count. The page is never changed by a carry out of the address.
- R4: With modeDown 1, each accepted strobe subtracts 1 from the working address, modulo 2^16. The count still subtracts 1.
- R5: With modeWord 0, busAddr[23:16] is the working page and busAddr[15:0] is the working address.
- R6: With modeWord 1, busAddr[0] is 0, busAddr[16:1] is the working address and busAddr[23:17] is page bits [7:1]. Page bit 0 has no effect.
- R7: tc is high only in a cycle where an accepted strobe finds the count at zero. That strobe still steps the address, and the count rolls to all ones.
- R8: With modeAuto 1, the clock edge after the terminal strobe restores page, address and count from the base copies, and masked stays 0.
- R9: With modeAuto 0, the terminal strobe sets masked. masked stays set until a maskClr pulse. While masked is set, strobes change nothing and tc stays low.
- R10: A strobe in the same cycle as a register write is ignored. Only the write takes effect.
- R11: Transfers never alter the base copies, so repeated reloads restore the same programmed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrSel | input | 2 | Register select: 0 page, 1 address, 2 count |
| wrData | input | 16 | Write data, low bits used for the page |
| modeWord | input | 1 | 1 selects shifted word addressing |
| modeDown | input | 1 | 1 makes the address count down |
| modeAuto | input | 1 | 1 enables reload from base at terminal count |
| maskClr | input | 1 | Clears the channel mask |
| xferStb | input | 1 | One transfer completed this cycle |
| busAddr | output | 24 | Formed bus address |
| curCount | output | 16 | Working transfer count |
| tc | output | 1 | Terminal count pulse |
| masked | output | 1 | Channel mask state |

## Verification
The bench sweeps all 256 page values in both address modes. A shifter that kept page bit 0, or left bit 0 live in word mode, would show a wrong upper byte or an odd address.

It runs the address across the 16-bit boundary in both directions. A carry leaking into the page would corrupt the top bits.

It sweeps the starting count from 0 to 5 and checks that tc appears only on the strobe that finds zero. An off-by-one terminal compare would fire one strobe early or late.

It repeats reload services several times to catch a base copy that drifts with transfers. It also checks that writes win over coincident strobes, and that a masked channel holds its address and count.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    SEL_PAGE  = 2'd0,
    SEL_ADDR  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPage;
    logic loadAddr;
    logic loadCount;
    logic step;
    logic reload;
  } dpCmd_t;

endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic       modeAuto,
  input  logic       maskClr,
  input  logic       xferStb,
  input  logic       countZero,
  output dpCmd_t     cmd,
  output logic       tcPulse,
  output logic       maskState
);

  regSel_e selDec;
  logic    reloadPend;
  logic    stepOk;

  assign selDec = regSel_e'(wrSel);

  // a strobe counts only when no write, no mask and no reload is pending
  assign stepOk  = xferStb && !wrEn && !maskState && !reloadPend;
  assign tcPulse = stepOk && countZero;

  always_comb begin
    cmd           = '0;
    cmd.loadPage  = wrEn && (selDec == SEL_PAGE);
    cmd.loadAddr  = wrEn && (selDec == SEL_ADDR);
    cmd.loadCount = wrEn && (selDec == SEL_COUNT);
    cmd.step      = stepOk;
    cmd.reload    = reloadPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadPend <= 1'b0;
      maskState  <= 1'b1;
    end else begin
      reloadPend <= tcPulse && modeAuto;
      if (tcPulse && !modeAuto) begin
        maskState <= 1'b1;
      end else if (maskClr) begin
        maskState <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int WR_W   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCmd_t                   cmd,
  input  logic [WR_W-1:0]          wrData,
  input  logic                     modeWord,
  input  logic                     modeDown,
  output logic [PAGE_W+ADDR_W-1:0] busAddr,
  output logic [CNT_W-1:0]         curCount,
  output logic                     countZero
);

  localparam int OUT_W = PAGE_W + ADDR_W;

  logic [PAGE_W-1:0] basePage, curPage;
  logic [ADDR_W-1:0] baseAddr, curAddr;
  logic [CNT_W-1:0]  baseCount;
  logic [ADDR_W-1:0] nextAddr;
  logic [OUT_W-1:0]  byteAddr, wordAddr;

  assign countZero = (curCount == '0);
  assign nextAddr  = modeDown ? (curAddr - ADDR_W'(1)) : (curAddr + ADDR_W'(1));

  // base registers change only on writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      basePage  <= '0;
      baseAddr  <= '0;
      baseCount <= '0;
    end else begin
      if (cmd.loadPage)  basePage  <= wrData[PAGE_W-1:0];
      if (cmd.loadAddr)  baseAddr  <= wrData[ADDR_W-1:0];
      if (cmd.loadCount) baseCount <= wrData[CNT_W-1:0];
    end
  end

  // working registers: reload or step, then writes take precedence
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPage  <= '0;
      curAddr  <= '0;
      curCount <= '0;
    end else begin
      if (cmd.reload) begin
        curPage  <= basePage;
        curAddr  <= baseAddr;
        curCount <= baseCount;
      end else if (cmd.step) begin
        curAddr  <= nextAddr;
        curCount <= curCount - CNT_W'(1);
      end
      if (cmd.loadPage)  curPage  <= wrData[PAGE_W-1:0];
      if (cmd.loadAddr)  curAddr  <= wrData[ADDR_W-1:0];
      if (cmd.loadCount) curCount <= wrData[CNT_W-1:0];
    end
  end

  assign byteAddr = {curPage, curAddr};

  generate
    if (PAGE_W > 1) begin : gWordWide
      assign wordAddr = {curPage[PAGE_W-1:1], curAddr, 1'b0};
    end else begin : gWordNarrow
      assign wordAddr = {curAddr, 1'b0};
    end
  endgenerate

  assign busAddr = modeWord ? wordAddr : byteAddr;

endmodule

// File: rtl/dma_chan_addr.sv
module dma_chan_addr
  import dma_chan_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [1:0]               wrSel,
  input  logic [15:0]              wrData,
  input  logic                     modeWord,
  input  logic                     modeDown,
  input  logic                     modeAuto,
  input  logic                     maskClr,
  input  logic                     xferStb,
  output logic [PAGE_W+ADDR_W-1:0] busAddr,
  output logic [CNT_W-1:0]         curCount,
  output logic                     tc,
  output logic                     masked
);

  dpCmd_t cmd;
  logic   countZero;

  dma_chan_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .modeAuto  (modeAuto),
    .maskClr   (maskClr),
    .xferStb   (xferStb),
    .countZero (countZero),
    .cmd       (cmd),
    .tcPulse   (tc),
    .maskState (masked)
  );

  dma_chan_dp #(
    .PAGE_W (PAGE_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .WR_W   (16)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .wrData    (wrData),
    .modeWord  (modeWord),
    .modeDown  (modeDown),
    .busAddr   (busAddr),
    .curCount  (curCount),
    .countZero (countZero)
  );

endmodule

// File: rtl/dma_chan_addr_chk.sv
module dma_chan_addr_chk #(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic [1:0]               wrSel,
  input logic [15:0]              wrData,
  input logic                     modeAuto,
  input logic                     xferStb,
  input logic [PAGE_W+ADDR_W-1:0] busAddr,
  input logic [CNT_W-1:0]         curCount,
  input logic                     tc,
  input logic                     masked
);

  a_r7_tc_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    tc |-> (xferStb && !masked && !wrEn));

  a_r7_tc_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    tc |-> (curCount == '0));

  a_r9_tc_sets_mask: assert property (@(posedge clk) disable iff (!rstN)
    (tc && !modeAuto) |=> masked);

  a_r8_auto_keeps_clear: assert property (@(posedge clk) disable iff (!rstN)
    (tc && modeAuto) |=> !masked);

  a_r9_masked_holds_count: assert property (@(posedge clk) disable iff (!rstN)
    (masked && !wrEn && !tc) |=> $stable(curCount));

  a_r10_count_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd2) |=> (curCount == $past(wrData[CNT_W-1:0])));

endmodule

bind dma_chan_addr dma_chan_addr_chk #(
  .PAGE_W (PAGE_W),
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .wrData   (wrData),
  .modeAuto (modeAuto),
  .xferStb  (xferStb),
  .busAddr  (busAddr),
  .curCount (curCount),
  .tc       (tc),
  .masked   (masked)
);

// File: tb/sim_dma_chan_addr.sv
`timescale 1ns/1ps
module sim_dma_chan_addr;

  logic        clk = 1'b0;
  logic        rstN, wrEn, modeWord, modeDown, modeAuto, maskClr, xferStb;
  logic [1:0]  wrSel;
  logic [15:0] wrData;
  logic [23:0] busAddr;
  logic [15:0] curCount;
  logic        tc, masked;
  int          nChecks = 0;
  int          nFail = 0;

  always #2 clk = ~clk;

  dma_chan_addr u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .modeWord(modeWord), .modeDown(modeDown), .modeAuto(modeAuto),
    .maskClr(maskClr), .xferStb(xferStb), .busAddr(busAddr),
    .curCount(curCount), .tc(tc), .masked(masked)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic strobe(output logic tcSeen);
    xferStb = 1'b1;
    #1 tcSeen = tc;
    @(negedge clk);
    xferStb = 1'b0;
  endtask

  task automatic clearMask();
    maskClr = 1'b1;
    @(negedge clk);
    maskClr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic t;
    logic [15:0] expA, expC;
    rstN = 1'b0; wrEn = 1'b0; wrSel = 2'd0; wrData = '0;
    modeWord = 1'b0; modeDown = 1'b0; modeAuto = 1'b0;
    maskClr = 1'b0; xferStb = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busAddr", busAddr, 0);
    chk("R1 curCount", curCount, 0);
    chk("R1 masked", masked, 1);
    chk("R1 tc", tc, 0);
    rstN = 1'b1;
    @(negedge clk);
    clearMask();
    chk("R9 maskClr", masked, 0);

    // R5 / R6: page sweep in both address modes
    wr(2'd1, 16'h1234);
    for (int p = 0; p < 256; p++) begin
      wr(2'd0, 16'(p));
      modeWord = 1'b0; #1;
      chk("R5 byte map", busAddr, {8'(p), 16'h1234});
      modeWord = 1'b1; #1;
      chk("R6 word map", busAddr, {p[7:1], 16'h1234, 1'b0});
      modeWord = 1'b0;
    end

    // R3 / R7 / R9: increment across wrap, non-auto
    wr(2'd0, 16'h005A);
    wr(2'd1, 16'hFFFE);
    wr(2'd2, 16'd3);
    for (int k = 0; k < 4; k++) begin
      strobe(t);
      expA = 16'hFFFE + 16'(k + 1);
      expC = 16'd3 - 16'(k + 1);
      chk("R7 tc position", t, (k == 3));
      chk("R3 inc addr", busAddr, {8'h5A, expA});
      chk("R3 count", curCount, expC);
    end
    chk("R9 mask set", masked, 1);
    strobe(t);
    chk("R9 masked tc", t, 0);
    chk("R9 masked addr", busAddr, {8'h5A, 16'h0002});
    chk("R9 masked count", curCount, 16'hFFFF);
    repeat (2) @(negedge clk);
    chk("R9 mask sticky", masked, 1);
    clearMask();
    chk("R9 cleared", masked, 0);

    // R4: decrement across wrap
    modeDown = 1'b1;
    wr(2'd1, 16'h0001);
    wr(2'd2, 16'd2);
    for (int k = 0; k < 3; k++) begin
      strobe(t);
      expA = 16'h0001 - 16'(k + 1);
      chk("R4 dec addr", busAddr, {8'h5A, expA});
      chk("R7 tc dec", t, (k == 2));
    end
    clearMask();
    modeDown = 1'b0;

    // R8 / R11: repeated reload services
    modeAuto = 1'b1;
    wr(2'd0, 16'h0033);
    wr(2'd1, 16'h1000);
    wr(2'd2, 16'd1);
    for (int s = 0; s < 3; s++) begin
      strobe(t);
      chk("R7 no early tc", t, 0);
      chk("R3 auto step", busAddr, {8'h33, 16'h1001});
      strobe(t);
      chk("R7 auto tc", t, 1);
      chk("R7 final step", busAddr, {8'h33, 16'h1002});
      chk("R7 roll count", curCount, 16'hFFFF);
      @(negedge clk);
      chk("R8 reload addr", busAddr, {8'h33, 16'h1000});
      chk("R11 reload count", curCount, 16'd1);
      chk("R8 mask clear", masked, 0);
    end

    // R7 sweep over start counts
    wr(2'd1, 16'h0000);
    for (int n = 0; n < 6; n++) begin
      wr(2'd2, 16'(n));
      for (int k = 0; k <= n; k++) begin
        strobe(t);
        chk("R7 sweep tc", t, (k == n));
      end
      @(negedge clk);
      chk("R8 sweep reload", curCount, 16'(n));
      chk("R8 sweep addr", busAddr, {8'h33, 16'h0000});
    end

    // R10: write wins over coincident strobe
    wr(2'd2, 16'd5);
    wr(2'd1, 16'h0200);
    wrEn = 1'b1; wrSel = 2'd1; wrData = 16'h0100; xferStb = 1'b1;
    #1 chk("R10 no tc", tc, 0);
    @(negedge clk);
    wrEn = 1'b0; xferStb = 1'b0;
    chk("R10 addr", busAddr, {8'h33, 16'h0100});
    chk("R10 count", curCount, 16'd5);

    // R2: unused select changes nothing
    wr(2'd3, 16'hFFFF);
    chk("R2 sel3 addr", busAddr, {8'h33, 16'h0100});
    chk("R2 sel3 count", curCount, 16'd5);

    finishRun();
  end

endmodule